// File: doc/BRIEF.md
# Edge-Aligned Oversampling Bit Sampler

This block recovers bits from a serial line that runs at roughly one eighth of the local clock, for example 16 Mbit/s against 125 MHz. The transmitter clock is not available. The nominal bit period is a fraction of a clock (125/16 = 7.8125 cycles), so no integer divider fits it.

The line first passes through a flop synchronizer. A change on the synchronized level is a transition. Each transition sets a phase counter back to zero, and that counter otherwise counts modulo the 16-bit window length. A set of sixteen mid-bit positions, one for each bit slot of the window, is computed from parameters. The block takes a sample whenever the counter lands on one of these positions.

Between transitions the counter runs freely through the window, so long runs of equal bits use the later positions. A run longer than the window reuses the positions after the counter wraps. Framing and frequency tracking belong to downstream logic.

Top module: `os_bit_sampler`

## Requirements
- R1: The line passes two synchronizer flops before use. After reset, with the line at 0, a change to 1 made just before clock edge T0 produces the first `bit_vld_o` pulse after edge T7, when the first sample position is 4.
- R2: The phase counter counts modulo PERIOD (125): after 124 it returns to 0. With the line held constant, strobes keep coming at the same positions shifted by 125 cycles for each pass through the window.
- R3: A transition sets the phase counter to 0 on the cycle after it is detected, so strobe timing restarts from each edge.
- R4: A sample is taken when the counter equals one of 4, 12, 19, 27, 35, 43, 51, 58, 66, 74, 82, 90, 97, 105, 113 or 121. Each position k is floor((125*k + 67)/16). A counter value of c is followed one cycle later by a strobe carrying the synchronized line level.
- R5: After reset, no strobe is produced until the first transition has been seen.
- R6: `bit_vld_o` is high for exactly one cycle per captured bit.
- R7: For a stream whose bits last 125/16 cycles on average (7 or 8 cycles each), every bit from the first transition on is delivered exactly once and in order. This holds for runs of equal bits longer than 16.
- R8: On a cycle where a transition is detected, no sample is taken, even if the counter is on a sample position.
- R9: Reset clears the synchronizer, the counter, the alignment state and both outputs to 0.
- R10: `bit_o` changes only together with a `bit_vld_o` pulse and holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Asynchronous serial line |
| bit_o | output | 1 | Last recovered bit, registered |
| bit_vld_o | output | 1 | One-cycle strobe marking a new `bit_o` |

## Verification
The bench uses the default parameters: a window of 125 cycles, sixteen slots and a position offset of 67/16 cycle.

With the line held after a single edge, it checks the exact cycle of twenty strobes, which carries the sequence across the counter wrap. It drives streams with 7/8-cycle bit lengths taken from an accumulator, including runs of 18 and 20 equal bits, which only the reused window can capture correctly. A 5-cycle pulse places a transition exactly on the first sample position, which exercises the suppression rule.

// File: rtl/os_sampler_pkg.sv
`timescale 1ns/100ps
package os_sampler_pkg;

  // Mid-bit position of slot k, offset given in 1/slots of a clock.
  function automatic int unsigned slot_pos(input int unsigned k,
                                           input int unsigned period,
                                           input int unsigned slots,
                                           input int unsigned ofs);
    return (period * k + ofs) / slots;
  endfunction

endpackage

// File: rtl/os_sync.sv
`timescale 1ns/100ps
module os_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/os_edge_det.sv
`timescale 1ns/100ps
module os_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic edge_o,
  output logic aligned_o
);
  logic lvl_d;
  logic aligned_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_d     <= 1'b0;
      aligned_q <= 1'b0;
    end else begin
      lvl_d <= lvl_i;
      if (edge_o) aligned_q <= 1'b1;
    end
  end

  assign edge_o    = lvl_i ^ lvl_d;
  assign aligned_o = aligned_q;

  // R5: alignment is only gained through a transition
  p_align_needs_edge_r5: assert property (@(posedge clk) disable iff (rst)
    (!aligned_q && !edge_o) |=> !aligned_q);
  // R5: once aligned, stays aligned until reset
  p_align_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    aligned_q |=> aligned_q);
endmodule

// File: rtl/os_phase_cnt.sv
`timescale 1ns/100ps
module os_phase_cnt #(
  parameter int unsigned PERIOD = 125,
  parameter int unsigned CW     = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (clear_i || cnt_q == LAST) cnt_q <= '0;
    else                              cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
  p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == LAST) |=> (cnt_q == '0));
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + CW'(1)));
  p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/os_slot_match.sv
`timescale 1ns/100ps
module os_slot_match
  import os_sampler_pkg::*;
#(
  parameter int unsigned PERIOD    = 125,
  parameter int unsigned SLOTS     = 16,
  parameter int unsigned PHASE_OFS = 67,
  parameter int unsigned CW        = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cnt_i,
  output logic          hit_o
);
  logic [SLOTS-1:0] hit_vec;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam int unsigned POS = slot_pos(k, PERIOD, SLOTS, PHASE_OFS);
    assign hit_vec[k] = (cnt_i == CW'(POS));
  end

  assign hit_o = |hit_vec;

  // R4: sample positions are distinct, at most one slot matches
  p_slots_distinct_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: rtl/os_bit_sampler.sv
`timescale 1ns/100ps
module os_bit_sampler #(
  parameter int unsigned PERIOD      = 125,
  parameter int unsigned SLOTS       = 16,
  parameter int unsigned PHASE_OFS   = 67,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic bit_o,
  output logic bit_vld_o
);
  localparam int unsigned CW = $clog2(PERIOD);

  logic          lvl;
  logic          edge_det;
  logic          aligned;
  logic [CW-1:0] phase;
  logic          slot_hit;
  logic          take;
  logic          bit_q;
  logic          vld_q;

  os_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (line_i),
    .q_o (lvl)
  );

  os_edge_det u_edge (
    .clk       (clk),
    .rst       (rst),
    .lvl_i     (lvl),
    .edge_o    (edge_det),
    .aligned_o (aligned)
  );

  os_phase_cnt #(.PERIOD(PERIOD), .CW(CW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear_i (edge_det),
    .cnt_o   (phase)
  );

  os_slot_match #(
    .PERIOD    (PERIOD),
    .SLOTS     (SLOTS),
    .PHASE_OFS (PHASE_OFS),
    .CW        (CW)
  ) u_match (
    .clk   (clk),
    .rst   (rst),
    .cnt_i (phase),
    .hit_o (slot_hit)
  );

  assign take = aligned && slot_hit && !edge_det;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= take;
      if (take) bit_q <= lvl;
    end
  end

  assign bit_o     = bit_q;
  assign bit_vld_o = vld_q;

  p_edge_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    edge_det |=> !bit_vld_o);
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    bit_vld_o |=> !bit_vld_o);
  p_hold_between_r10: assert property (@(posedge clk) disable iff (rst)
    !bit_vld_o |-> $stable(bit_o));
  p_quiet_unaligned_r5: assert property (@(posedge clk) disable iff (rst)
    !aligned |=> !bit_vld_o);
  p_restart_r3: assert property (@(posedge clk) disable iff (rst)
    edge_det |=> (phase == '0));
endmodule

// File: tb/test_os_bit_sampler.sv
`timescale 1ns/100ps
module test_os_bit_sampler;
  localparam int PER = 125;
  localparam int SL  = 16;
  localparam int POS_TAB [16] = '{4, 12, 19, 27, 35, 43, 51, 58,
                                  66, 74, 82, 90, 97, 105, 113, 121};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_i = 1'b0;
  logic bit_o;
  logic bit_vld_o;

  always #2.5 clk = ~clk;

  os_bit_sampler i_os_bit_sampler (
    .clk       (clk),
    .rst       (rst),
    .line_i    (line_i),
    .bit_o     (bit_o),
    .bit_vld_o (bit_vld_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit sb_on = 1'b0;
  bit exp_q[$];
  int n_strobe = 0;
  int n_ones = 0;
  bit last_bit = 1'b0;
  int acc = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Monitor: pops expected bits and compares as strobes appear
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst) begin
        last_bit = 1'b0;
      end else if (bit_vld_o) begin
        n_strobe++;
        if (bit_o) n_ones++;
        last_bit = bit_o;
        if (sb_on) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R7 extra strobe", 1, 0);
          end else begin
            bit e;
            e = exp_q.pop_front();
            chk(bit_o == e, "R7 stream bit", int'(bit_o), int'(e));
          end
        end
      end else begin
        if (bit_o != last_bit) chk(1'b0, "R10 bit_o moved without strobe", int'(bit_o), int'(last_bit));
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    line_i = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(bit_o == 1'b0, "R9 bit_o in reset", int'(bit_o), 0);
    chk(bit_vld_o == 1'b0, "R9 bit_vld_o in reset", int'(bit_vld_o), 0);
    rst = 1'b0;
  endtask

  // Driver: one bit, length from a 125/16 accumulator; called at a negedge
  task automatic send_bit(input bit b);
    int dur;
    acc = acc + PER;
    dur = acc / SL;
    acc = acc % SL;
    if (sb_on) exp_q.push_back(b);
    line_i = b;
    repeat (dur) @(negedge clk);
  endtask

  task automatic send_run(input bit b, input int n);
    for (int i = 0; i < n; i++) send_bit(b);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    report();
  end

  initial begin
    int snap;
    int ones0;
    int k;
    bit prev_v;

    // R9: reset state
    do_reset();

    // R5: idle line gives no strobe
    snap = n_strobe;
    repeat (300) @(negedge clk);
    chk(n_strobe == snap, "R5 strobes before first edge", n_strobe - snap, 0);

    // R1/R4/R2/R6: exact strobe cycles after a single edge, across the wrap
    line_i = 1'b1;
    k = 0;
    prev_v = 1'b0;
    for (int i = 0; i < 160; i++) begin
      @(posedge clk);
      #1;
      if (bit_vld_o) begin
        int e;
        e = POS_TAB[k % 16] + PER * (k / 16) + 3;
        if (k == 0) chk(i == 7, "R1 first strobe latency", i, 7);
        chk(i == e, "R4 strobe cycle", i, e);
        chk(bit_o == 1'b1, "R4 sampled level", int'(bit_o), 1);
        chk(!prev_v, "R6 strobe width", 2, 1);
        k++;
      end
      prev_v = bit_vld_o;
    end
    chk(k == 20, "R2 strobes across wrap", k, 20);

    // R7/R3: streams with long runs through the scoreboard
    do_reset();
    acc = 0;
    sb_on = 1'b1;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    send_run(1'b0, 3); send_bit(1'b1);
    send_run(1'b1, 20);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    send_run(1'b0, 18);
    send_bit(1'b1); send_bit(1'b0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7 bits left undelivered", exp_q.size(), 0);
    sb_on = 1'b0;
    exp_q.delete();

    // R8: a transition on a sample position suppresses the strobe
    do_reset();
    snap = n_strobe;
    ones0 = n_ones;
    line_i = 1'b1;
    repeat (5) @(negedge clk);
    line_i = 1'b0;
    repeat (40) @(negedge clk);
    chk(n_ones == ones0, "R8 strobe on suppressed slot", n_ones - ones0, 0);
    chk(n_strobe - snap >= 4, "R3 strobes after re-phase", n_strobe - snap, 4);

    // R9/R5: reset drops alignment
    do_reset();
    snap = n_strobe;
    repeat (200) @(negedge clk);
    chk(n_strobe == snap, "R9 alignment cleared by reset", n_strobe - snap, 0);

    report();
  end
endmodule